// File: doc/BRIEF.md
# Serial Register-Access Slave

This block is a slave serial control port. It gives an external host read and write access to a small bank of 16-bit registers over four wires: a serial clock, an active-low select, a serial data input and a serial data output. While select is low, the host clocks in a 16-bit command word and then one or more 16-bit data words. The command word selects the direction, turns address auto-increment on or off and names a 12-bit register address.

The serial pins are sampled by the block's own system clock. A short synchronizer and an edge detector turn the serial clock into rising and falling strobes, so every register runs in the single system clock domain. The serial clock must stay high and low for at least four system clock cycles each. During writes, the serial input is echoed on the serial output, so that devices sharing the lines can all be written with the same burst. During reads, the serial output carries the register contents instead.

Top module: `serial_regs_top`

## Requirements
- R1: Each transaction begins with a 16-bit command word, shifted in MSB first on rising serial-clock edges while select is low. Bit 15 is the direction (1 = read, 0 = write), bit 12 is auto-increment, bits 11:0 are the address, and bits 14:13 have no effect.
- R2: A write with auto-increment 0 stores exactly one data word at the commanded address. Any further data words in the same select period are not stored.
- R3: A write with auto-increment 1 stores the first data word at the commanded address and each later word at the previous address plus one.
- R4: A read drives the addressed register MSB first on the serial output. Each bit changes after a falling serial-clock edge and is valid at the next rising edge. The first bit follows the falling edge after the command word's last bit.
- R5: A read with auto-increment 1 returns successive addresses word after word. A read with auto-increment 0 returns one word, and the output is 0 for every later word.
- R6: During the command word and during write data words, the serial output repeats the serial input bit that is currently applied.
- R7: The word address counts from 0xFFF to 0x000 during auto-increment.
- R8: Addresses at or above the implemented register count ignore writes and read as zero.
- R9: Raising select clears the bit count and the word state, so the next select period starts with a command word. A partial word is discarded, and the serial output is 0 while select is high.
- R10: After reset, the serial output is 0 and the port waits for a command word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock from the host, bursting |
| ser_csn | input | 1 | Active-low select |
| ser_din | input | 1 | Serial data from the host |
| ser_dout | output | 1 | Serial data to the host (registered) |

## Verification
The bench builds the block with 16 implemented registers, a 16-bit word and a 12-bit address. This leaves most of the 4096-entry address space unimplemented, so a single short burst starting at 0xFFE reaches the dropped writes, the zero reads and the wrap to address 0. The serial clock runs at the minimum of four system clocks per half period, which places every output bit as late as the timing allows.

// File: rtl/serial_regs_pkg.sv
package serial_regs_pkg;
  // Command word field positions (16-bit command word)
  localparam int CMD_RD_POS = 15;
  localparam int CMD_AI_POS = 12;

  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_DATA = 2'd1,
    PH_DONE = 2'd2
  } phase_t;
endpackage

// File: rtl/srx_sync_edge.sv
module srx_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_in,
  input  logic csn_in,
  input  logic din_in,
  output logic rise,
  output logic fall,
  output logic sel,
  output logic din_s
);
  // bit 2 = select (idle high), bit 1 = serial clock, bit 0 = data
  logic [2:0] chain [STAGES];
  logic       sclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= 3'b100;
      sclk_d <= 1'b0;
    end else begin
      chain[0] <= {csn_in, sclk_in, din_in};
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      sclk_d <= chain[STAGES-1][1];
    end
  end

  assign rise  = chain[STAGES-1][1] & ~sclk_d;
  assign fall  = ~chain[STAGES-1][1] & sclk_d;
  assign sel   = ~chain[STAGES-1][2];
  assign din_s = chain[STAGES-1][0];
endmodule

// File: rtl/srx_ctrl.sv
module srx_ctrl
  import serial_regs_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 12,
  localparam int CNT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              rise,
  input  logic              din_s,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output phase_t            phase,
  output logic              rd_mode,
  output logic              ai_mode,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [CNT_W-1:0]  bit_cnt
);
  logic [WORD_W-2:0] shreg;
  logic              last_bit;

  assign last_bit = (bit_cnt == CNT_W'(WORD_W - 1));

  always_ff @(posedge clk) begin
    if (rst || !sel) begin
      bit_cnt  <= '0;
      phase    <= PH_CMD;
      rd_mode  <= 1'b0;
      ai_mode  <= 1'b0;
      wr_en    <= 1'b0;
      rd_req   <= 1'b0;
      cur_addr <= '0;
      if (rst) begin
        shreg   <= '0;
        wr_addr <= '0;
        wr_data <= '0;
        rd_addr <= '0;
      end
    end else begin
      wr_en  <= 1'b0;
      rd_req <= 1'b0;
      if (rise) begin
        shreg   <= {shreg[WORD_W-3:0], din_s};
        bit_cnt <= bit_cnt + 1'b1;
        if (last_bit) begin
          unique case (phase)
            PH_CMD: begin
              rd_mode  <= shreg[CMD_RD_POS-1];
              ai_mode  <= shreg[CMD_AI_POS-1];
              cur_addr <= {shreg[ADDR_W-2:0], din_s};
              phase    <= PH_DATA;
              if (shreg[CMD_RD_POS-1]) begin
                rd_req  <= 1'b1;
                rd_addr <= {shreg[ADDR_W-2:0], din_s};
              end
            end
            PH_DATA: begin
              if (!rd_mode) begin
                wr_en   <= 1'b1;
                wr_addr <= cur_addr;
                wr_data <= {shreg, din_s};
              end
              if (ai_mode) begin
                cur_addr <= cur_addr + 1'b1;
                if (rd_mode) begin
                  rd_req  <= 1'b1;
                  rd_addr <= cur_addr + 1'b1;
                end
              end else begin
                phase <= PH_DONE;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/srx_regfile.sv
module srx_regfile #(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  rd_idx_q;
  logic              rd_hit_q;
  logic              wr_hit;

  assign wr_hit = ({1'b0, wr_addr} < (ADDR_W+1)'(DEPTH));

  always_ff @(posedge clk) begin
    if (wr_en && wr_hit) mem[wr_addr[IDX_W-1:0]] <= wr_data;
    rd_idx_q <= rd_addr[IDX_W-1:0];
    rd_hit_q <= ({1'b0, rd_addr} < (ADDR_W+1)'(DEPTH));
  end

  assign rd_data = rd_hit_q ? mem[rd_idx_q] : '0;
endmodule

// File: rtl/srx_txout.sv
module srx_txout
  import serial_regs_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              fall,
  input  logic              din_s,
  input  phase_t            phase,
  input  logic              rd_mode,
  input  logic              load,
  input  logic [WORD_W-1:0] load_data,
  output logic              dout
);
  logic [WORD_W-1:0] out_sr;
  logic              load_q;

  always_ff @(posedge clk) begin
    if (rst || !sel) begin
      dout   <= 1'b0;
      out_sr <= '0;
      load_q <= 1'b0;
    end else begin
      load_q <= load;
      if (rd_mode && phase != PH_CMD) begin
        if (load_q) begin
          out_sr <= load_data;
        end else if (fall) begin
          dout   <= (phase == PH_DATA) ? out_sr[WORD_W-1] : 1'b0;
          out_sr <= {out_sr[WORD_W-2:0], 1'b0};
        end
      end else begin
        dout <= din_s;
      end
    end
  end
endmodule

// File: rtl/serial_regs_top.sv
module serial_regs_top
  import serial_regs_pkg::*;
#(
  parameter int REG_COUNT   = 16,
  parameter int WORD_W      = 16,
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(WORD_W)
) (
  input  logic clk,
  input  logic rst,
  input  logic ser_clk,
  input  logic ser_csn,
  input  logic ser_din,
  output logic ser_dout
);
  logic              rise, fall, sel, din_s;
  logic              wr_en, rd_req, rd_mode, ai_mode;
  logic [ADDR_W-1:0] wr_addr, rd_addr, cur_addr;
  logic [WORD_W-1:0] wr_data, rd_data;
  logic [CNT_W-1:0]  bit_cnt;
  phase_t            phase;

  srx_sync_edge #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .sclk_in(ser_clk), .csn_in(ser_csn), .din_in(ser_din),
    .rise(rise), .fall(fall), .sel(sel), .din_s(din_s)
  );

  srx_ctrl #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rst(rst), .sel(sel), .rise(rise), .din_s(din_s),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .phase(phase),
    .rd_mode(rd_mode), .ai_mode(ai_mode), .cur_addr(cur_addr), .bit_cnt(bit_cnt)
  );

  srx_regfile #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .DEPTH(REG_COUNT)) regs_i (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  srx_txout #(.WORD_W(WORD_W)) tx_i (
    .clk(clk), .rst(rst), .sel(sel), .fall(fall), .din_s(din_s),
    .phase(phase), .rd_mode(rd_mode), .load(rd_req), .load_data(rd_data),
    .dout(ser_dout)
  );
endmodule

// File: rtl/srx_checker.sv
module srx_checker
  import serial_regs_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 12,
  localparam int CNT_W = $clog2(WORD_W)
) (
  input logic              clk,
  input logic              rst,
  input logic              sel,
  input logic              rise,
  input logic              din_s,
  input logic              dout,
  input logic              wr_en,
  input logic              rd_mode,
  input logic              ai_mode,
  input phase_t            phase,
  input logic [ADDR_W-1:0] cur_addr,
  input logic [CNT_W-1:0]  bit_cnt
);
  logic word_end;
  assign word_end = sel && rise && (bit_cnt == CNT_W'(WORD_W - 1));

  AST_DESEL_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !sel |=> (bit_cnt == '0 && phase == PH_CMD)); // R9

  AST_BIT_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (sel && rise) |=> (bit_cnt == CNT_W'($past(bit_cnt) + 1'b1))); // R1

  AST_AUTO_INC_STEP: assert property (@(posedge clk) disable iff (rst)
    (word_end && phase == PH_DATA && ai_mode) |=>
      (cur_addr == ADDR_W'($past(cur_addr) + 1'b1))); // R7

  AST_SINGLE_WORD_DONE: assert property (@(posedge clk) disable iff (rst)
    (word_end && phase == PH_DATA && !ai_mode) |=>
      (phase == PH_DONE && $stable(cur_addr))); // R2

  AST_ECHO_PATH: assert property (@(posedge clk) disable iff (rst)
    (sel && !(rd_mode && phase != PH_CMD)) |=> (dout == $past(din_s))); // R6

  AST_NO_WRITE_ON_READ: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !rd_mode); // R4
endmodule

bind serial_regs_top srx_checker #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .sel(sel), .rise(rise), .din_s(din_s), .dout(ser_dout),
  .wr_en(wr_en), .rd_mode(rd_mode), .ai_mode(ai_mode), .phase(phase),
  .cur_addr(cur_addr), .bit_cnt(bit_cnt)
);

// File: tb/serial_regs_top_tb_top.sv
module serial_regs_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int REG_COUNT  = 16;
  localparam int HALF       = 4;

  logic clk = 1'b0;
  logic rst, ser_clk, ser_csn, ser_din, ser_dout;
  int   vectors = 0;
  int   miscompares = 0;
  logic [15:0] model [REG_COUNT];
  logic [15:0] wd [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_regs_top #(.REG_COUNT(REG_COUNT)) dut_i (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_csn(ser_csn),
    .ser_din(ser_din), .ser_dout(ser_dout)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic act, input logic exp, input string tag);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: ser_dout=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Host-side transaction with a behavioural model of the register bank.
  task automatic xfer(input logic [15:0] cmd, input int nwords, input int cut);
    logic        rd = cmd[15];
    logic        ai = cmd[12];
    logic [11:0] a  = cmd[11:0];
    int          total = (cut > 0) ? cut : (nwords + 1) * 16;
    int          sent = 0;
    ser_csn = 1'b0;
    wait_clk(3);
    for (int w = 0; w <= nwords; w++) begin
      logic        active = (w == 1) || ai;
      logic [15:0] cur;
      string       tag;
      if (w == 0) begin cur = cmd; tag = "R1"; end
      else if (!rd) begin cur = wd[w-1]; tag = "R6"; end
      else if (!active) begin cur = 16'h0; tag = "R5"; end
      else if (a >= REG_COUNT) begin cur = 16'h0; tag = "R8"; end
      else begin cur = model[a]; tag = (w == 1) ? "R4" : "R5"; end
      for (int b = 15; b >= 0; b--) begin
        if (sent < total) begin
          logic exp;
          ser_clk = 1'b0;
          ser_din = (rd && w > 0) ? 1'b0 : cur[b];
          wait_clk(HALF);
          exp = (w == 0 || !rd) ? ser_din : cur[b];
          check(ser_dout, exp, tag);
          ser_clk = 1'b1;
          wait_clk(HALF);
          sent++;
        end
      end
      if (w > 0 && sent >= (w + 1) * 16 && active) begin
        if (!rd && a < REG_COUNT) model[a[3:0]] = wd[w-1];
        if (ai) a = a + 12'd1;
      end
    end
    ser_clk = 1'b0;
    wait_clk(HALF);
    ser_csn = 1'b1;
    wait_clk(5);
    check(ser_dout, 1'b0, "R9");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    miscompares++;
    $display("FAIL watchdog: run did not finish, actual hang expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst = 1'b1; ser_clk = 1'b0; ser_csn = 1'b1; ser_din = 1'b0;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(2);
    check(ser_dout, 1'b0, "R10");

    // R3: burst write 16 words starting at address 0
    for (int i = 0; i < 16; i++) wd[i] = 16'hA53C ^ 16'(i * 16'h1111);
    xfer(16'h1000, 16, 0);

    // R1 R2: bits 14:13 set, single write at 5, second word must not land
    wd[0] = 16'h1234; wd[1] = 16'hFFFF;
    xfer(16'h6005, 2, 0);

    // R4 R5: burst read of all registers
    xfer(16'h9000, 16, 0);

    // R5: single read of 5 followed by an extra word that reads 0
    xfer(16'h8005, 2, 0);

    // R8: single read of an unimplemented address
    xfer(16'h8123, 1, 0);

    // R7 R8: burst write across 0xFFF -> 0x000, first two dropped
    wd[0] = 16'hBEEF; wd[1] = 16'hCAFE; wd[2] = 16'h0F0F;
    xfer(16'h1FFE, 3, 0);

    // R7 R8: burst read across the wrap
    xfer(16'h9FFF, 2, 0);

    // R9: write aborted mid data word, then read back the old value
    wd[0] = 16'h5555;
    xfer(16'h0003, 1, 24);
    xfer(16'h8003, 1, 0);

    // R9: abort inside a command word, then a read with bits 14:13 set (R1)
    xfer(16'h0007, 1, 7);
    xfer(16'hE007, 2, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule